// File: doc/BRIEF.md
# Power-up strap sampling controller

This block lets a set of clock-output pins double as configuration inputs at power-up. After the supply monitor reports power good, every shared pin driver stays in high impedance for a fixed sampling window. During that window the external pull-up or pull-down resistors set the pin levels. On the last cycle of the window the synchronized pin levels are stored as configuration bits. In the same cycle the output enables go high, and each pin then starts to carry its clock.

The stored bits can be cleared only by a loss of power. There is no separate logic reset. The power-good input is the block's only reset source, and its release is synchronized to the reference clock. A low power-good clears the configuration, and the next rise starts a complete new window. Shared pin 0 (set by the parameter `SS_IDX`) carries the spread-width strap. The block decodes that strap together with the live active-low spread-enable input into a modulation mode for the synthesizer. The clock driven onto each pin is gated so that it only starts at a rising edge of its source. This means the first pulse a load sees is always a full one.

Top module: `strap_sampler`

## Requirements
- R1: While `pwr_good_i` is low, `cfg_valid_o`, `cfg_o`, `pin_oe_o`, `pin_clk_o` and `spread_mode_o` are all zero.
- R2: After `pwr_good_i` rises, `cfg_valid_o` rises after exactly `WIN_CYC + 2` rising edges of `clk_i`. The 2 extra edges come from the reset synchronizer. During the whole window `pin_oe_o` stays all-zero.
- R3: Each bit of `cfg_o` holds the level of its `pin_lvl_i` bit as seen at the rising edge two edges before the capture edge, so low is stored as 0 and high as 1. A pin change made after that edge is not captured.
- R4: `pin_oe_o` goes all-ones in the same cycle that `cfg_valid_o` rises.
- R5: Once `cfg_valid_o` is high, neither it nor `cfg_o` changes under any activity on `pin_lvl_i` or `spread_en_ni`, for as long as `pwr_good_i` stays high.
- R6: `pin_clk_o[k]` is never high while `clk_src_i[k]` is low. It only rises together with a rising edge of `clk_src_i[k]`. At most two falling edges of the source after `cfg_valid_o` rises, it follows `clk_src_i[k]` exactly.
- R7: `spread_mode_o` is 2'b00 (no modulation) when `cfg_valid_o` is low or `spread_en_ni` is 1. Otherwise it is 2'b01 (1.25 % spread) when the captured bit `cfg_o[SS_IDX]` is 0, and 2'b10 (3.75 % spread) when that bit is 1. The value 2'b11 never appears.
- R8: A fall of `pwr_good_i`, including one in the middle of a window, clears all state asynchronously. The next rise starts a full new window and takes a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| pwr_good_i | input | 1 | Supply valid; low acts as the power-on reset |
| pin_lvl_i | input | N_PINS | Raw levels sensed on the shared pins |
| spread_en_ni | input | 1 | Active-low modulation enable, live |
| clk_src_i | input | N_PINS | Synthesized clocks destined for the shared pins |
| cfg_o | output | N_PINS | Captured strap bits |
| cfg_valid_o | output | 1 | Capture done, held until power-good drops |
| pin_oe_o | output | N_PINS | Output enable per shared pin driver |
| pin_clk_o | output | N_PINS | Gated clock per shared pin |
| spread_mode_o | output | 2 | Modulation mode: 00 off, 01 narrow, 10 wide |

## Verification
The bench counts edges from the rise of power-good and expects the capture on exactly the edge `WIN_CYC + 2`. A design that drops the reset synchronizer, or counts one cycle too few or too many, therefore misses that edge. The pins are flipped in the very last cycle of the window. A design with a single synchronizer stage would latch the flipped value, while a correct design keeps the settled one. After capture the bench keeps the pins and the spread enable busy. A design that keeps sampling, or that lets the enable change the stored bits, shows up as a changed `cfg_o`. Power-good is also dropped halfway through a window. A design that resumes counting instead of restarting would raise valid too early. The pin clocks are sampled every nanosecond, so an ungated or badly gated output shows up as a short first pulse or as a high output while its source is low.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'b00,
    SPR_NARROW = 2'b01,
    SPR_WIDE   = 2'b10
  } spread_mode_e;

  function automatic spread_mode_e decode_spread(logic valid, logic en_n, logic wide);
    if (!valid || en_n) return SPR_OFF;
    return wide ? SPR_WIDE : SPR_NARROW;
  endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync (
  input  logic clk_i,
  input  logic pwr_good_i,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) stage_q <= 2'b00;
    else             stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/strap_window.sv
module strap_window #(
  parameter int N_PINS  = 2,
  parameter int WIN_CYC = 28636
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_lvl_i,
  output logic [N_PINS-1:0] cfg_o,
  output logic              cfg_valid_o
);
  localparam int                CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WIN_CYC - 1);

  logic [N_PINS-1:0] sync1_q, sync2_q, cfg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      cnt_q   <= '0;
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sync1_q <= pin_lvl_i;
      sync2_q <= sync1_q;
      // counter freezes after capture; only power loss reopens the window
      if (!valid_q) begin
        if (cnt_q == LAST) begin
          cfg_q   <= sync2_q;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign cfg_valid_o = valid_q;
endmodule

// File: rtl/strap_clk_gate.sv
module strap_clk_gate (
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic [1:0] en_q;

  // enable crosses into the source domain and only moves while the source is low
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 2'b00;
    else         en_q <= {en_q[0], en_i};
  end

  assign clk_o = clk_src_i & en_q[1];
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int N_PINS  = 2,
  parameter int WIN_CYC = 28636,
  parameter int SS_IDX  = 0
) (
  input  logic              clk_i,
  input  logic              pwr_good_i,
  input  logic [N_PINS-1:0] pin_lvl_i,
  input  logic              spread_en_ni,
  input  logic [N_PINS-1:0] clk_src_i,
  output logic [N_PINS-1:0] cfg_o,
  output logic              cfg_valid_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] pin_clk_o,
  output logic [1:0]        spread_mode_o
);
  import strap_pkg::*;

  logic rst_n;
  logic valid;
  logic [N_PINS-1:0] cfg;

  strap_rst_sync i_rst_sync (
    .clk_i      (clk_i),
    .pwr_good_i (pwr_good_i),
    .rst_no     (rst_n)
  );

  strap_window #(
    .N_PINS  (N_PINS),
    .WIN_CYC (WIN_CYC)
  ) i_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pin_lvl_i   (pin_lvl_i),
    .cfg_o       (cfg),
    .cfg_valid_o (valid)
  );

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    strap_clk_gate i_gate (
      .clk_src_i (clk_src_i[k]),
      .rst_ni    (rst_n),
      .en_i      (valid),
      .clk_o     (pin_clk_o[k])
    );
  end

  assign pin_oe_o      = {N_PINS{valid}};
  assign cfg_o         = cfg;
  assign cfg_valid_o   = valid;
  assign spread_mode_o = decode_spread(valid, spread_en_ni, cfg[SS_IDX]);
endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
  parameter int N_PINS = 2
) (
  input logic              clk_i,
  input logic              pwr_good_i,
  input logic              spread_en_ni,
  input logic [N_PINS-1:0] clk_src_i,
  input logic [N_PINS-1:0] cfg_o,
  input logic              cfg_valid_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic [N_PINS-1:0] pin_clk_o,
  input logic [1:0]        spread_mode_o
);
  a_r1_cleared_when_off: assert property (@(posedge clk_i)
    (!pwr_good_i && $past(!pwr_good_i)) |->
      (!cfg_valid_o && cfg_o == '0 && pin_oe_o == '0 && spread_mode_o == 2'b00));

  a_r4_oe_rises_with_valid: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(cfg_valid_o) |-> (pin_oe_o == {N_PINS{1'b1}} && $past(pin_oe_o) == '0));

  a_r2_oe_off_in_window: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    !cfg_valid_o |-> pin_oe_o == '0);

  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    cfg_valid_o |=> cfg_valid_o);

  a_r5_cfg_hold: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    cfg_valid_o |=> $stable(cfg_o));

  a_r6_no_high_on_low_src: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (pin_clk_o & ~clk_src_i) == '0);

  a_r7_mode_off: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (spread_en_ni || !cfg_valid_o) |-> spread_mode_o == 2'b00);

  a_r7_mode_legal: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    spread_mode_o != 2'b11);
endmodule

bind strap_sampler strap_sampler_chk #(.N_PINS(N_PINS)) i_strap_chk (
  .clk_i         (clk_i),
  .pwr_good_i    (pwr_good_i),
  .spread_en_ni  (spread_en_ni),
  .clk_src_i     (clk_src_i),
  .cfg_o         (cfg_o),
  .cfg_valid_o   (cfg_valid_o),
  .pin_oe_o      (pin_oe_o),
  .pin_clk_o     (pin_clk_o),
  .spread_mode_o (spread_mode_o)
);

// File: tb/test_strap_sampler.sv
`timescale 1ns/100ps
module test_strap_sampler;
  localparam int N   = 2;
  localparam int WIN = 40;
  localparam int SS  = 0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] src = '0;
  always #7  src[0] = ~src[0];
  always #11 src[1] = ~src[1];

  logic         pg   = 1'b0;
  logic [N-1:0] lvl  = '0;
  logic         en_n = 1'b0;

  logic [N-1:0] cfg, oe, pclk;
  logic         valid;
  logic [1:0]   mode;

  strap_sampler #(.N_PINS(N), .WIN_CYC(WIN), .SS_IDX(SS)) i_strap_sampler (
    .clk_i         (clk),
    .pwr_good_i    (pg),
    .pin_lvl_i     (lvl),
    .spread_en_ni  (en_n),
    .clk_src_i     (src),
    .cfg_o         (cfg),
    .cfg_valid_o   (valid),
    .pin_oe_o      (oe),
    .pin_clk_o     (pclk),
    .spread_mode_o (mode)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int r6_bad = 0;
  bit mon_match = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_mode(logic v, logic dis, logic wide);
    if (!v || dis) return 2'b00;
    return wide ? 2'b10 : 2'b01;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // R6: fine-grained sampling of pin clocks against their sources
  initial begin
    logic [N-1:0] out_p, src_p;
    out_p = '0; src_p = '0;
    #0.5;
    forever begin
      #1;
      for (int k = 0; k < N; k++) begin
        if (pclk[k] && !src[k]) r6_bad++;
        if (pclk[k] && !out_p[k] && src_p[k]) r6_bad++;
        if (mon_match && pclk[k] !== src[k]) r6_bad++;
      end
      out_p = pclk;
      src_p = src;
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic power_down();
    @(negedge clk);
    #2 pg = 1'b0;
    mon_match = 0;
    #1;
    chk(valid == 1'b0 && cfg == '0 && oe == '0, "R8 async clear on power loss",
        {valid, oe, cfg}, 0);
    repeat (3) @(negedge clk);
    chk(valid == 1'b0 && cfg == '0 && oe == '0 && pclk == '0 && mode == 2'b00,
        "R1 idle while power off", {mode, pclk, valid, oe, cfg}, 0);
  endtask

  task automatic power_up(input logic [N-1:0] fin, input bit late_flip);
    @(negedge clk);
    lvl = N'($urandom);
    pg  = 1'b1;
    for (int e = 1; e <= WIN + 2; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e <= WIN + 1)
        chk(valid == 1'b0 && oe == '0 && cfg == '0 && mode == 2'b00,
            "R2 drivers off during window", {mode, valid, oe, cfg}, 0);
      if (e < WIN - 4)       lvl = N'($urandom);
      else if (e < WIN)      lvl = fin;
      else if (e == WIN)     lvl = late_flip ? ~fin : fin;
    end
    chk(valid == 1'b1, "R2 valid on edge WIN+2", valid, 1);
    chk(oe == {N{1'b1}}, "R4 enables with valid", oe, {N{1'b1}});
    chk(cfg == fin, "R3 captured levels", cfg, fin);
  endtask

  task automatic post_checks(input logic [N-1:0] fin);
    r6_bad = 0;
    repeat (5) @(negedge clk);
    mon_match = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lvl  = N'($urandom);
      en_n = 1'($urandom);
      #1;
      chk(mode == exp_mode(1'b1, en_n, fin[SS]), "R7 spread mode decode",
          mode, exp_mode(1'b1, en_n, fin[SS]));
      @(posedge clk);
      @(negedge clk);
      chk(cfg == fin && valid == 1'b1, "R5 capture held", {valid, cfg}, {1'b1, fin});
    end
    en_n = 1'b0;
    chk(r6_bad == 0, "R6 glitch-free pin clocks", r6_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    chk(valid == 1'b0 && cfg == '0 && oe == '0 && pclk == '0 && mode == 2'b00,
        "R1 reset state", {mode, pclk, valid, oe, cfg}, 0);

    power_up(2'b01, 1'b0);          // wide spread strap
    post_checks(2'b01);
    power_down();

    power_up(2'b10, 1'b1);          // narrow strap, pins flip in last cycle
    post_checks(2'b10);
    power_down();

    // R8: abort halfway through a window, then a full fresh window
    @(negedge clk);
    lvl = 2'b00;
    pg  = 1'b1;
    repeat (WIN / 2) @(negedge clk);
    chk(valid == 1'b0, "R8 no capture mid-window", valid, 0);
    power_down();
    power_up(2'b11, 1'b0);
    post_checks(2'b11);
    power_down();

    for (int r = 0; r < 3; r++) begin
      logic [N-1:0] f;
      f = N'($urandom);
      power_up(f, r[0]);
      post_checks(f);
      power_down();
    end

    finish_run();
  end
endmodule